// File: doc/BRIEF.md
# Display PHY Post-Divider Clock Tree

This block derives a byte-rate strobe and a pixel-rate strobe from a fast source clock. A chain of counters runs on the source clock. Each counter turns the strobe it receives into a slower strobe, so every rate in the tree is a one-cycle enable pulse, not a derived clock. A power-of-two stage comes first. A programmable bit-rate divider follows it, and a fixed divide-by-8 tap then gives the byte strobe. A four-way selector picks the pixel path from four sources: the bit strobe, the bit strobe halved, the first-stage strobe, or the first-stage strobe quartered. A programmable pixel divider follows the selector. An enable bit gates both outputs.

Software programs the tree through a plain write port with three 8-bit words. Word 0 holds the bit divider in bits [3:0] and the pixel divider in bits [7:4]. Word 1 holds the pixel source select in bits [1:0], the external-source select in bit 2 and the output enable in bit 5. Word 2 holds the power-of-two exponent in bits [1:0]. The block has no data stream, so it has no valid/ready handshake. The write port and the strobes are plain level and pulse signals. When the external-source bit is set, the tree advances only on cycles where `ext_tick` is high. Another tree then paces this one.

Top module: `dispclk_divtree`

## Requirements
- R1: The first stage divides the source strobe by 2^N, where N is word 2 bits [1:0]. The byte strobe period in source ticks is 8 × 2^N × B.
- R2: The bit divider ratio B is the value of word 0 bits [3:0] itself (one-based).
- R3: The byte strobe is the bit strobe divided by a fixed 8. Each byte pulse is one cycle wide.
- R4: Word 1 bits [1:0] select the pixel source: 0 = bit strobe, 1 = bit strobe / 2, 2 = first-stage strobe, 3 = first-stage strobe / 4.
- R5: The pixel strobe is the selected source divided by P, the one-based value of word 0 bits [7:4].
- R6: While word 1 bit 5 is clear, neither strobe pulses. A write that clears the bit silences both outputs from the second cycle after the write.
- R7: While word 1 bit 2 is set, the tree advances only on cycles where `ext_tick` is high. With `ext_tick` held low, neither output pulses.
- R8: A divider field of 0 acts as divide-by-1, so the tree never stalls. Every counter stays below its ratio.
- R9: A new divider value or pixel select takes effect only at the next terminal count of the divider it affects. The period in progress when the write lands completes at the old length.
- R10: Reset clears N, the select, the external bit and the enable, and sets B and P to 1. Both outputs are low after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock; every register runs on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the configuration words |
| wr_addr | input | 2 | Word index: 0 dividers, 1 path/enable, 2 exponent |
| wr_data | input | 8 | Write data |
| ext_tick | input | 1 | Advance strobe used when the external source is selected |
| byte_tick | output | 1 | Byte-rate enable pulse |
| pix_tick | output | 1 | Pixel-rate enable pulse |

## Verification
The bench builds the tree with its default parameters. These are a 2-bit exponent, 4-bit one-based dividers and fixed taps of 8, 2 and 4. With these values every selector input and the extreme ratios come within reach: the slowest byte strobe (960 source ticks) and a zero field are both covered within a short run. Periods are measured at the ports under each pixel source, with an external pacing strobe, with the enable cleared, and across a pixel divider change. The change checks that exactly one period of the old length completes before the new length applies.

// File: rtl/dpt_pkg.sv
package dpt_pkg;
  localparam int WORD_W  = 8;
  localparam int DIV_W   = 4;
  localparam int OD_W    = 2;
  localparam int PIX_LSB = 4;
  localparam int EXT_BIT = 2;
  localparam int EN_BIT  = 5;

  localparam logic [1:0] ADDR_DIVS   = 2'd0;
  localparam logic [1:0] ADDR_PATH   = 2'd1;
  localparam logic [1:0] ADDR_OUTDIV = 2'd2;

  typedef enum logic [1:0] {
    SRC_BIT  = 2'd0,
    SRC_HALF = 2'd1,
    SRC_OUT  = 2'd2,
    SRC_POST = 2'd3
  } pix_src_e;

  typedef struct packed {
    logic [OD_W-1:0]  od_exp;
    logic [DIV_W-1:0] bit_div;
    logic [DIV_W-1:0] pix_div;
    pix_src_e         src;
    logic             ext;
    logic             en;
  } tree_cfg_t;
endpackage

// File: rtl/dpt_cfg_regs.sv
module dpt_cfg_regs
  import dpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output tree_cfg_t         cfg
);
  tree_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.od_exp  <= '0;
      cfg_q.bit_div <= DIV_W'(1);
      cfg_q.pix_div <= DIV_W'(1);
      cfg_q.src     <= SRC_BIT;
      cfg_q.ext     <= 1'b0;
      cfg_q.en      <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_DIVS: begin
          cfg_q.bit_div <= wr_data[DIV_W-1:0];
          cfg_q.pix_div <= wr_data[PIX_LSB +: DIV_W];
        end
        ADDR_PATH: begin
          cfg_q.src <= pix_src_e'(wr_data[1:0]);
          cfg_q.ext <= wr_data[EXT_BIT];
          cfg_q.en  <= wr_data[EN_BIT];
        end
        ADDR_OUTDIV: cfg_q.od_exp <= wr_data[OD_W-1:0];
        default: ;
      endcase
    end
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/dpt_tick_div.sv
module dpt_tick_div #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_in,
  input  logic [W-1:0] ratio_new,
  output logic         tick_out
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] ratio_q;
  logic         last;

  assign last     = (cnt_q == ratio_q - W'(1));
  assign tick_out = tick_in && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= W'(1);
    end else if (tick_in) begin
      if (last) begin
        cnt_q   <= '0;
        ratio_q <= (ratio_new == '0) ? W'(1) : ratio_new;
      end else begin
        cnt_q <= cnt_q + W'(1);
      end
    end
  end

  // R8: the counter never escapes its range, so a terminal count always comes
  p_cnt_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < ratio_q);

  // R9: the active ratio only moves at a terminal count
  p_ratio_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_out |=> $stable(ratio_q));
endmodule

// File: rtl/dpt_pix_sel.sv
module dpt_pix_sel
  import dpt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] taps,
  input  pix_src_e   sel_new,
  input  logic       load,
  output logic       src_tick
);
  pix_src_e sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sel_q <= SRC_BIT;
    else if (load) sel_q <= sel_new;
  end

  assign src_tick = taps[sel_q];

  // R9: the pixel source changes only at a pixel terminal count
  p_sel_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(sel_q));
endmodule

// File: rtl/dispclk_divtree.sv
module dispclk_divtree
  import dpt_pkg::*;
#(
  parameter int BYTE_RATIO = 8,
  parameter int HALF_RATIO = 2,
  parameter int POST_RATIO = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              ext_tick,
  output logic              byte_tick,
  output logic              pix_tick
);
  localparam int POW_W = 1 << OD_W;
  localparam int MAX_FIX = (BYTE_RATIO > HALF_RATIO) ?
                           ((BYTE_RATIO > POST_RATIO) ? BYTE_RATIO : POST_RATIO) :
                           ((HALF_RATIO > POST_RATIO) ? HALF_RATIO : POST_RATIO);
  localparam int FIX_W = $clog2(MAX_FIX + 1);

  tree_cfg_t  cfg;
  logic       src_tick, od_tick, bit_tick, mux_tick, pix_tc;
  logic [2:0] fix_in, fix_out;
  logic [POW_W-1:0] od_ratio;

  function automatic int fix_ratio(input int idx);
    case (idx)
      0:       return BYTE_RATIO;
      1:       return HALF_RATIO;
      default: return POST_RATIO;
    endcase
  endfunction

  dpt_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg(cfg)
  );

  assign src_tick = cfg.ext ? ext_tick : 1'b1;
  assign od_ratio = POW_W'(1) << cfg.od_exp;

  dpt_tick_div #(.W(POW_W)) u_od (
    .clk(clk), .rst_n(rst_n), .tick_in(src_tick),
    .ratio_new(od_ratio), .tick_out(od_tick)
  );

  dpt_tick_div #(.W(DIV_W)) u_bit (
    .clk(clk), .rst_n(rst_n), .tick_in(od_tick),
    .ratio_new(cfg.bit_div), .tick_out(bit_tick)
  );

  // fixed taps: 0 byte (from bit), 1 half-rate (from bit), 2 post (from first stage)
  assign fix_in = {od_tick, bit_tick, bit_tick};

  for (genvar g = 0; g < 3; g++) begin : g_fix
    dpt_tick_div #(.W(FIX_W)) u_fix (
      .clk(clk), .rst_n(rst_n), .tick_in(fix_in[g]),
      .ratio_new(FIX_W'(fix_ratio(g))), .tick_out(fix_out[g])
    );
  end

  dpt_pix_sel u_psel (
    .clk(clk), .rst_n(rst_n),
    .taps({fix_out[2], od_tick, fix_out[1], bit_tick}),
    .sel_new(cfg.src), .load(pix_tc), .src_tick(mux_tick)
  );

  dpt_tick_div #(.W(DIV_W)) u_pix (
    .clk(clk), .rst_n(rst_n), .tick_in(mux_tick),
    .ratio_new(cfg.pix_div), .tick_out(pix_tc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_tick <= 1'b0;
      pix_tick  <= 1'b0;
    end else begin
      byte_tick <= cfg.en && fix_out[0];
      pix_tick  <= cfg.en && pix_tc;
    end
  end

  // R6: clearing the enable silences both strobes from the second cycle on
  p_gate_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_PATH && !wr_data[EN_BIT]) |=> ##1 (!byte_tick && !pix_tick));

  // R7: with the external source chosen, an idle ext_tick yields no pulse
  p_ext_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.ext && !ext_tick) |=> (!byte_tick && !pix_tick));

  // R3: byte pulses are a single cycle wide
  p_byte_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_tick |=> !byte_tick);
endmodule

// File: tb/dispclk_divtree_tb.sv
`timescale 1ns/1ps
module dispclk_divtree_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       ext_tick = 1'b0;
  logic       byte_tick, pix_tick;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit ext_run = 1'b0;
  int ext_ph = 0;
  bit finished = 1'b0;

  typedef struct {
    int    kind;
    int    exp;
    string tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  dispclk_divtree dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ext_tick(ext_tick),
    .byte_tick(byte_tick), .pix_tick(pix_tick)
  );

  always @(negedge clk) begin
    if (ext_run) begin
      ext_ph   = (ext_ph == 2) ? 0 : ext_ph + 1;
      ext_tick = (ext_ph == 2);
    end else begin
      ext_tick = 1'b0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic pick(input int kind);
    return (kind == 0) ? byte_tick : pix_tick;
  endfunction

  // monitor: pops expected periods and measures them at the ports
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        sb_item_t it;
        int t0;
        it = sb_q[0];
        while (!pick(it.kind)) @(negedge clk);
        t0 = cyc;
        @(negedge clk);
        while (!pick(it.kind)) @(negedge clk);
        chk(it.tag, cyc - t0, it.exp);
        void'(sb_q.pop_front());
      end
    end
  end

  task automatic expect_period(input int kind, input int exp, input string tag);
    sb_item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (3000) @(negedge clk);
  endtask

  task automatic count_pulses(input int n, output int nb, output int np);
    nb = 0; np = 0;
    repeat (n) begin
      @(negedge clk);
      if (byte_tick) nb++;
      if (pix_tick)  np++;
    end
  endtask

  initial begin
    int nb, np, t0, t1, t2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state, outputs idle
    count_pulses(100, nb, np);
    chk("R10 byte after reset", nb, 0);
    chk("R10 pix after reset", np, 0);

    // R3: defaults enabled, byte = bit/8 with N=0, B=1
    wr(2'd1, 8'h20);
    settle();
    expect_period(0, 8, "R3 byte default");
    expect_period(1, 1, "R5 pix default");

    // R1 R2: N=2, B=3, P=1, bit source
    wr(2'd2, 8'h02);
    wr(2'd0, 8'h13);
    settle();
    expect_period(0, 96, "R1 R2 byte N2 B3");
    expect_period(1, 12, "R4 pix bit source");

    // R4 R5: half-rate source, P=2
    wr(2'd0, 8'h23);
    wr(2'd1, 8'h21);
    settle();
    expect_period(1, 48, "R4 R5 pix half source");

    // R4: first-stage source, P=5
    wr(2'd0, 8'h53);
    wr(2'd1, 8'h22);
    settle();
    expect_period(1, 20, "R4 pix first-stage source");

    // R4: quartered first-stage source, P=7
    wr(2'd0, 8'h73);
    wr(2'd1, 8'h23);
    settle();
    expect_period(1, 112, "R4 pix post source");

    // R8: zero fields act as divide-by-1
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h20);
    settle();
    expect_period(0, 32, "R8 byte zero bit field");
    expect_period(1, 4, "R8 pix zero pix field");

    // R1: slowest byte strobe, N=3, B=15
    wr(2'd2, 8'h03);
    wr(2'd0, 8'h1F);
    settle();
    expect_period(0, 960, "R1 byte N3 B15");

    // R6: enable cleared
    wr(2'd1, 8'h00);
    repeat (3) @(negedge clk);
    count_pulses(2000, nb, np);
    chk("R6 byte gated", nb, 0);
    chk("R6 pix gated", np, 0);

    // R7: external pacing, one advance every 3 cycles
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h11);
    ext_run = 1'b1;
    wr(2'd1, 8'h24);
    settle();
    expect_period(0, 24, "R7 byte ext paced");
    expect_period(1, 3, "R7 pix ext paced");
    ext_run = 1'b0;
    repeat (5) @(negedge clk);
    count_pulses(300, nb, np);
    chk("R7 byte ext idle", nb, 0);
    chk("R7 pix ext idle", np, 0);

    // R9: pixel divider change completes the running period first
    wr(2'd1, 8'h20);
    wr(2'd0, 8'h32);
    settle();
    @(negedge clk);
    while (!pix_tick) @(negedge clk);
    t0 = cyc;
    wr(2'd0, 8'h52);
    while (!pix_tick) @(negedge clk);
    t1 = cyc;
    @(negedge clk);
    while (!pix_tick) @(negedge clk);
    t2 = cyc;
    chk("R9 period at write keeps old ratio", t1 - t0, 6);
    chk("R9 following period uses new ratio", t2 - t1, 10);

    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(20ns * 150000);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule